// File: doc/BRIEF.md
# Strobed Overvoltage Fault Filter

This block watches a one-bit overvoltage comparator during the part of each switching period in which the power switch is off. When the switch turns off, the drain node and the auxiliary winding ring for a while, so the block first lets a fixed settling delay pass. Only then does it open a short sampling window. A comparator high seen inside that window marks the current switching period as over threshold.

Marked periods are counted only while they follow one another without a gap. Any period that ends with no mark clears the count. When the count reaches the trip limit, a sticky fault flag rises. The flag blocks further switching and asks the surrounding supervisor for an auto-restart sequence. Only the supervisor's clear input or reset lowers the flag again. The settling delay, the window length and the trip limit are parameters given in clock cycles.

Top module: `ovp_strobe_filter`

## Requirements
- R1: After reset the fault output is low, and the first switching period starts from a count of zero.
- R2: The comparator is ignored while gate_on is high: a comparator high during on-time never adds to the count.
- R3: Off-time clocks are numbered from 0, starting with the first clock in which gate_on is low. The comparator is sampled only on off-clocks DELAY_CLKS through DELAY_CLKS+WIN_CLKS-1. A comparator high on any other off-clock is ignored.
- R4: A switching period adds at most one to the count, however many window clocks see the comparator high.
- R5: At the cycle_start pulse that ends a period with no capture, the count returns to zero. This includes a period whose off-time ended before the window opened.
- R6: The fault rises at the clock edge that samples the capture completing TRIP_COUNT consecutive marked periods. Fewer consecutive marked periods leave it low.
- R7: Once high, the fault stays high through any number of later periods, clean or marked, until a clear.
- R8: A clock edge with fault_clr high lowers the fault and zeroes the count. After the clear, a full run of TRIP_COUNT new marked periods is needed to raise the fault again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_on | input | 1 | High while the power switch is driven on |
| cycle_start | input | 1 | One-clock pulse at the start of each oscillator period |
| ovp_cmp | input | 1 | Digitized comparator output, high when over threshold |
| fault_clr | input | 1 | Supervisor clear for the fault flag and the count |
| ovp_fault | output | 1 | Sticky overvoltage fault, high stops switching |

## Verification
The hardest situation to reach from the ports is a comparator pulse that lies just at the edge of the sampling window. The same pulse must be placed against off-times that end before, inside or after that window. Only then can an edge clock that is wrongly counted, or a short off-time that is wrongly kept, change the outcome. The bench uses a small setting (delay 3, window 2, trip 4). It sweeps every off-time length, every pulse start position and two pulse lengths, with and without a comparator high during on-time. Each pattern is repeated for four periods, then followed by a clean period and a clear. A model of the window and the count in the bench predicts the fault after every period. For directed runs it also predicts the exact off-clock at which the fault rises.

// File: rtl/ovp_pkg.sv
// Package: shared types for the strobed overvoltage filter.
// Assumes nothing beyond a standard SystemVerilog compile order (package first).
package ovp_pkg;

    // Position inside one off-time of the power switch.
    typedef enum logic [1:0] {
        PH_ON     = 2'd0,  // switch driven on, no sampling
        PH_SETTLE = 2'd1,  // off, waiting for ringing to settle
        PH_WINDOW = 2'd2,  // off, comparator is sampled
        PH_DONE   = 2'd3   // off, window has closed
    } off_phase_e;

endpackage : ovp_pkg

// File: rtl/ovp_off_timer.sv
// Module: ovp_off_timer
// Counts clocks since the power switch turned off and reports the off-time phase.
// Assumes gate_on is synchronous to clk. The count restarts on every clock with
// gate_on high. It saturates once the window has closed, so a long off-time
// cannot wrap it back into the window.
module ovp_off_timer
    import ovp_pkg::*;
#(
    parameter int DELAY_CLKS = 275,
    parameter int WIN_CLKS   = 62
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate_on,
    output off_phase_e phase
);

    localparam int LIMIT = DELAY_CLKS + WIN_CLKS;
    localparam int TW    = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] DELAY_V = TW'(DELAY_CLKS);
    localparam logic [TW-1:0] LIMIT_V = TW'(LIMIT);

    logic [TW-1:0] off_clks;

    // Count off-time clocks, hold at the limit, restart while the switch is on.
    always_ff @(posedge clk) begin
        if (!rst_n || gate_on) begin
            off_clks <= '0;
        end else if (off_clks != LIMIT_V) begin
            off_clks <= off_clks + 1'b1;
        end
    end

    // Decode the current clock's off-time index into a phase.
    always_comb begin
        if (gate_on) begin
            phase = PH_ON;
        end else if (off_clks < DELAY_V) begin
            phase = PH_SETTLE;
        end else if (off_clks < LIMIT_V) begin
            phase = PH_WINDOW;
        end else begin
            phase = PH_DONE;
        end
    end

endmodule : ovp_off_timer

// File: rtl/ovp_cycle_gate.sv
// Module: ovp_cycle_gate
// Turns window samples into at most one capture per switching period.
// Assumes cycle_start is a one-clock pulse. A capture on the clock of
// cycle_start belongs to the period that begins there.
module ovp_cycle_gate
    import ovp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  off_phase_e phase,
    input  logic       ovp_cmp,
    input  logic       cycle_start,
    input  logic       fault_clr,
    output logic       in_window,
    output logic       capture,
    output logic       taken
);

    // Window open only during the sampling phase of the off-time.
    always_comb begin
        in_window = (phase == PH_WINDOW);
        capture   = in_window && ovp_cmp && (!taken || cycle_start);
    end

    // Remember whether the running period already produced a capture.
    always_ff @(posedge clk) begin
        if (!rst_n || fault_clr) begin
            taken <= 1'b0;
        end else if (capture) begin
            taken <= 1'b1;
        end else if (cycle_start) begin
            taken <= 1'b0;
        end
    end

endmodule : ovp_cycle_gate

// File: rtl/ovp_trip_counter.sv
// Module: ovp_trip_counter
// Counts consecutive marked periods and holds the sticky fault flag.
// Assumes 'taken' tells whether the period now ending had a capture. The count
// saturates at TRIP_COUNT, and the fault stays high until clear or reset.
module ovp_trip_counter #(
    parameter int TRIP_COUNT = 4,
    parameter int CNT_W      = $clog2(TRIP_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             taken,
    input  logic             cycle_start,
    input  logic             fault_clr,
    output logic [CNT_W-1:0] hit_count,
    output logic             fault
);

    localparam logic [CNT_W-1:0] TRIP_V = CNT_W'(TRIP_COUNT);

    logic [CNT_W-1:0] base_count;
    logic [CNT_W-1:0] next_count;

    // Drop the run at a period boundary without capture, then add a new capture.
    always_comb begin
        base_count = (cycle_start && !taken) ? '0 : hit_count;
        next_count = (capture && base_count != TRIP_V) ? base_count + 1'b1 : base_count;
    end

    // Register the run length.
    always_ff @(posedge clk) begin
        if (!rst_n || fault_clr) begin
            hit_count <= '0;
        end else begin
            hit_count <= next_count;
        end
    end

    // Raise the sticky fault when the run reaches the trip limit.
    always_ff @(posedge clk) begin
        if (!rst_n || fault_clr) begin
            fault <= 1'b0;
        end else if (next_count == TRIP_V) begin
            fault <= 1'b1;
        end
    end

endmodule : ovp_trip_counter

// File: rtl/ovp_strobe_filter.sv
// Module: ovp_strobe_filter (top)
// Strobed, digitally filtered overvoltage detector for a switching converter.
// Assumes all inputs are synchronous to clk and cycle_start pulses once per
// oscillator period. The output ovp_fault is meant to block the gate driver
// and start the auto-restart sequence of the supervisor.
module ovp_strobe_filter
    import ovp_pkg::*;
#(
    parameter int DELAY_CLKS = 275,
    parameter int WIN_CLKS   = 62,
    parameter int TRIP_COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_on,
    input  logic cycle_start,
    input  logic ovp_cmp,
    input  logic fault_clr,
    output logic ovp_fault
);

    localparam int CNT_W = $clog2(TRIP_COUNT + 1);

    off_phase_e       phase;
    logic             in_window;
    logic             capture;
    logic             cycle_taken;
    logic [CNT_W-1:0] hit_count;

    ovp_off_timer #(
        .DELAY_CLKS (DELAY_CLKS),
        .WIN_CLKS   (WIN_CLKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_on (gate_on),
        .phase   (phase)
    );

    ovp_cycle_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .ovp_cmp     (ovp_cmp),
        .cycle_start (cycle_start),
        .fault_clr   (fault_clr),
        .in_window   (in_window),
        .capture     (capture),
        .taken       (cycle_taken)
    );

    ovp_trip_counter #(
        .TRIP_COUNT (TRIP_COUNT),
        .CNT_W      (CNT_W)
    ) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .taken       (cycle_taken),
        .cycle_start (cycle_start),
        .fault_clr   (fault_clr),
        .hit_count   (hit_count),
        .fault       (ovp_fault)
    );

endmodule : ovp_strobe_filter

// File: rtl/ovp_filter_chk.sv
// Module: ovp_filter_chk
// Checker bound to ovp_strobe_filter. It relates the ports to the run count
// and the per-period capture flag.
module ovp_filter_chk #(
    parameter int TRIP_COUNT = 4,
    parameter int CNT_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate_on,
    input logic             cycle_start,
    input logic             ovp_cmp,
    input logic             fault_clr,
    input logic             ovp_fault,
    input logic             in_window,
    input logic             taken,
    input logic [CNT_W-1:0] hit_count
);

    // R2
    on_time_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && !cycle_start && !fault_clr) |=> (hit_count == $past(hit_count)));

    // R4
    one_per_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !cycle_start) |=> (hit_count <= $past(hit_count)));

    // R5
    clean_period_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && !taken && !(in_window && ovp_cmp)) |=> (hit_count == '0));

    // R6
    trip_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovp_fault) |-> (hit_count == CNT_W'(TRIP_COUNT)));

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count <= CNT_W'(TRIP_COUNT));

    // R7
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp_fault && !fault_clr) |=> ovp_fault);

    // R8
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr |=> (!ovp_fault && hit_count == '0));

endmodule : ovp_filter_chk

bind ovp_strobe_filter ovp_filter_chk #(
    .TRIP_COUNT (TRIP_COUNT),
    .CNT_W      (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_on     (gate_on),
    .cycle_start (cycle_start),
    .ovp_cmp     (ovp_cmp),
    .fault_clr   (fault_clr),
    .ovp_fault   (ovp_fault),
    .in_window   (in_window),
    .taken       (cycle_taken),
    .hit_count   (hit_count)
);

// File: tb/ovp_strobe_filter_test.sv
// Bench for ovp_strobe_filter with a small configuration, swept near-exhaustively.
module ovp_strobe_filter_test;

    localparam int DLY  = 3;
    localparam int WIN  = 2;
    localparam int TRIP = 4;
    localparam int ON_LEN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_on = 1'b1;
    logic cycle_start = 1'b0;
    logic ovp_cmp = 1'b0;
    logic fault_clr = 1'b0;
    logic ovp_fault;

    int checks = 0;
    int failures = 0;
    int m_cnt = 0;
    bit m_fault = 1'b0;
    bit m_prev_hit = 1'b0;

    always #4 clk = ~clk;

    ovp_strobe_filter #(
        .DELAY_CLKS (DLY),
        .WIN_CLKS   (WIN),
        .TRIP_COUNT (TRIP)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_on     (gate_on),
        .cycle_start (cycle_start),
        .ovp_cmp     (ovp_cmp),
        .fault_clr   (fault_clr),
        .ovp_fault   (ovp_fault)
    );

    task automatic check(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: ovp_fault=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // First off-clock index that the window captures, or -1 if none.
    function automatic int first_hit(input int off_len, input int hp, input int hold);
        for (int j = hp; j < hp + hold; j++) begin
            if (j >= DLY && j < DLY + WIN && j < off_len) return j;
        end
        return -1;
    endfunction

    // One switching period: on-time, then off_len clocks with the comparator high
    // on off-clocks hp..hp+hold-1; cmp_on raises the comparator during on-time.
    task automatic run_cycle(input string tag, input int off_len, input int hp,
                             input int hold, input bit cmp_on, input bit each);
        int  hidx;
        bit  f_before;
        hidx = first_hit(off_len, hp, hold);
        if (!m_prev_hit) m_cnt = 0;
        f_before = m_fault;
        if (hidx >= 0) begin
            if (m_cnt < TRIP) m_cnt++;
            if (m_cnt == TRIP) m_fault = 1'b1;
        end
        m_prev_hit = (hidx >= 0);
        for (int i = 0; i < ON_LEN; i++) begin
            @(negedge clk);
            gate_on = 1'b1;
            cycle_start = (i == 0);
            ovp_cmp = cmp_on;
        end
        for (int j = 0; j < off_len; j++) begin
            @(negedge clk);
            gate_on = 1'b0;
            cycle_start = 1'b0;
            ovp_cmp = (j >= hp && j < hp + hold);
            @(posedge clk);
            #1;
            if (each) begin
                check(tag, ovp_fault,
                      (hidx >= 0 && j >= hidx) ? m_fault : f_before);
            end
        end
        if (!each) check(tag, ovp_fault, m_fault);
    endtask

    task automatic clear_fault();
        @(negedge clk);
        fault_clr = 1'b1;
        gate_on = 1'b1;
        cycle_start = 1'b0;
        ovp_cmp = 1'b0;
        @(posedge clk);
        #1;
        m_cnt = 0;
        m_fault = 1'b0;
        m_prev_hit = 1'b0;
        check("R8 clear", ovp_fault, 1'b0);
        @(negedge clk);
        fault_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 reset state
        check("R1 reset", ovp_fault, 1'b0);

        // R6 exact rise, one capture per period at off-clock 3
        for (int k = 0; k < TRIP; k++) run_cycle("R6 trip edge", 6, 3, 1, 1'b0, 1'b1);
        // R7 sticky through clean periods
        run_cycle("R7 sticky clean", 6, 0, 0, 1'b0, 1'b0);
        run_cycle("R7 sticky clean", 1, 0, 0, 1'b0, 1'b0);
        clear_fault();

        // R5 a clean period breaks the run
        for (int k = 0; k < TRIP - 1; k++) run_cycle("R5 run", 6, 4, 1, 1'b0, 1'b0);
        run_cycle("R5 clean break", 6, 0, 0, 1'b0, 1'b0);
        run_cycle("R5 after break", 6, 3, 1, 1'b0, 1'b0);
        // R5 short off-time resets the run even with comparator high
        for (int k = 0; k < TRIP - 2; k++) run_cycle("R5 run", 6, 3, 1, 1'b0, 1'b0);
        run_cycle("R5 short off", DLY, 0, DLY, 1'b0, 1'b0);
        run_cycle("R5 after short", 6, 3, 1, 1'b0, 1'b0);
        clear_fault();

        // R4 comparator high over the whole window counts once per period
        for (int k = 0; k < TRIP - 1; k++) run_cycle("R4 once", 8, DLY, WIN, 1'b0, 1'b0);
        clear_fault();

        // R2 comparator high during on-time only
        for (int k = 0; k < TRIP + 1; k++) run_cycle("R2 on-time", 6, 0, 0, 1'b1, 1'b0);

        // R3 sweep of off-time length, pulse start and pulse length
        for (int ol = 1; ol <= 7; ol++) begin
            for (int hp = 0; hp <= 6; hp++) begin
                for (int hl = 1; hl <= 2; hl++) begin
                    for (int k = 0; k < TRIP; k++) begin
                        run_cycle("R3 window sweep", ol, hp, hl, (hp + ol) % 2 == 1, 1'b0);
                    end
                    run_cycle("R7 sweep tail", ol, 0, 0, 1'b0, 1'b0);
                    clear_fault();
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule : ovp_strobe_filter_test